// File: doc/BRIEF.md
# Segment Descriptor Cache

This block keeps a hidden descriptor copy for each of four segment registers: code, stack, data and an extra data segment. Software sees only the 16-bit selector held in each register. When a selector is written, a descriptor fetched elsewhere arrives on the load port together with it. The block captures both the selector and the descriptor's base, size limit and access-rights byte in the matching entry.

Memory references name a segment and a 16-bit offset. The block uses only the cached base and limit to form a 24-bit physical address in the same cycle, with no descriptor re-read. It flags offsets that exceed the cached limit and references through entries that were never loaded. A load whose rights byte does not mark a segment descriptor is refused and reported. Descriptor fetch and privilege checking belong to neighbouring logic.

Top module: `segdesc_cache`

## Requirements
- R1: After synchronous reset every selector reads 0 and every entry is marked not loaded.
- R2: A load request whose rights byte has bit 4 set (segment descriptor) writes the selector, base, limit and rights into the entry chosen by the segment index at the next rising edge. The index values are 0 code, 1 stack, 2 data and 3 extra.
- R3: A load changes only the addressed entry. All other selectors and descriptors keep their values.
- R4: A load request whose rights byte has bit 4 clear is refused. The selector and entry keep their old values, and type_fault is high for exactly the one cycle after the request.
- R5: rd_selector shows the selector of the segment named by rd_seg combinationally. No port reads back base or limit.
- R6: When ref_valid is high, the segment is loaded and the offset does not exceed the limit, phys_addr equals the base plus the zero-extended offset modulo 2^24 and addr_valid is high in the same cycle. An offset equal to the limit is accepted.
- R7: An offset greater than the cached limit raises limit_fault in the same cycle and keeps addr_valid low.
- R8: A reference through an entry that is not loaded raises seg_unloaded, and keeps addr_valid and limit_fault low.
- R9: References never alter cached state. Repeated references give identical results.
- R10: Reloading a segment replaces its cached values, and later references use the new base and limit.
- R11: A reference made in the same cycle as a load to the same segment uses the values cached before that load. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Segment register write with fetched descriptor |
| ld_seg | input | 2 | Segment index of the write |
| ld_selector | input | 16 | Selector being written |
| ld_base | input | 24 | Descriptor base address |
| ld_limit | input | 16 | Descriptor segment size limit |
| ld_rights | input | 8 | Descriptor access-rights byte |
| type_fault | output | 1 | One-cycle pulse after a refused load |
| rd_seg | input | 2 | Segment index for selector readback |
| rd_selector | output | 16 | Selector of rd_seg |
| ref_valid | input | 1 | Memory reference request |
| ref_seg | input | 2 | Segment used by the reference |
| ref_offset | input | 16 | Offset within the segment |
| phys_addr | output | 24 | Cached base plus offset |
| addr_valid | output | 1 | Address usable (loaded, within limit) |
| limit_fault | output | 1 | Offset exceeds cached limit |
| seg_unloaded | output | 1 | Reference through an unloaded entry |
| ref_rights | output | 8 | Cached rights byte of the referenced segment |

## Verification
The hardest case to reach is a load and a reference aimed at the same segment in the same cycle. The bench holds both requests across one rising edge. It checks before the edge that the address still comes from the old base, and after the edge that it comes from the new one. Base wrap-around past 2^24 and an offset exactly at the limit are reached with chosen descriptor values. A refused load aimed at an already loaded segment shows at the ports that nothing changed.

// File: rtl/segcache_pkg.sv
package segcache_pkg;

    localparam int SEG_COUNT   = 4;
    localparam int SEG_IDX_W   = $clog2(SEG_COUNT);
    localparam int SEL_W       = 16;
    localparam int BASE_W      = 24;
    localparam int LIMIT_W     = 16;
    localparam int RIGHTS_W    = 8;
    localparam int OFFSET_W    = 16;
    localparam int SEGTYPE_BIT = 4;

    typedef enum logic [SEG_IDX_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef struct packed {
        logic [BASE_W-1:0]   base;
        logic [LIMIT_W-1:0]  limit;
        logic [RIGHTS_W-1:0] rights;
    } seg_desc_t;

    function automatic logic desc_is_segment(input logic [RIGHTS_W-1:0] rights);
        return rights[SEGTYPE_BIT];
    endfunction

    function automatic logic [BASE_W-1:0] form_addr(input logic [BASE_W-1:0] base,
                                                     input logic [OFFSET_W-1:0] off);
        return base + BASE_W'(off);
    endfunction

endpackage

// File: rtl/segcache_load_ctrl.sv
module segcache_load_ctrl
    import segcache_pkg::*;
#(
    parameter int N = SEG_COUNT,
    localparam int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_valid,
    input  logic [IW-1:0]       ld_seg,
    input  logic [RIGHTS_W-1:0] ld_rights,
    output logic [N-1:0]        we,
    output logic                type_fault
);

    logic accept;

    assign accept = ld_valid && desc_is_segment(ld_rights);

    always_comb begin
        we = '0;
        if (accept) we[ld_seg] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) type_fault <= 1'b0;
        else     type_fault <= ld_valid && !desc_is_segment(ld_rights);
    end

    // R3: at most one entry written per cycle
    a_r3_single_writer: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we));

    // R4: a refused request writes nothing
    a_r4_refused_no_write: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_rights[SEGTYPE_BIT]) |-> (we == '0));

endmodule

// File: rtl/segcache_entry_bank.sv
module segcache_entry_bank
    import segcache_pkg::*;
#(
    parameter int N = SEG_COUNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0]             we,
    input  logic [SEL_W-1:0]         ld_selector,
    input  seg_desc_t                ld_desc,
    output logic [N-1:0][SEL_W-1:0]  sel_arr,
    output seg_desc_t [N-1:0]        desc_arr,
    output logic [N-1:0]             loaded
);

    for (genvar i = 0; i < N; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_arr[i]  <= '0;
                desc_arr[i] <= '0;
                loaded[i]   <= 1'b0;
            end else if (we[i]) begin
                sel_arr[i]  <= ld_selector;
                desc_arr[i] <= ld_desc;
                loaded[i]   <= 1'b1;
            end
        end

        // R3, R9: entry only changes when its own write enable fires
        a_r3_entry_hold: assert property (@(posedge clk) disable iff (rst)
            !we[i] |=> ($stable(sel_arr[i]) && $stable(desc_arr[i])));

        // R1, R2: once loaded, stays loaded until reset
        a_r2_loaded_sticky: assert property (@(posedge clk) disable iff (rst)
            loaded[i] |=> loaded[i]);
    end

endmodule

// File: rtl/segcache_addr_gen.sv
module segcache_addr_gen
    import segcache_pkg::*;
#(
    parameter int N = SEG_COUNT,
    localparam int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_valid,
    input  logic [IW-1:0]       ref_seg,
    input  logic [OFFSET_W-1:0] ref_offset,
    input  seg_desc_t [N-1:0]   desc_arr,
    input  logic [N-1:0]        loaded,
    output logic [BASE_W-1:0]   phys_addr,
    output logic                addr_valid,
    output logic                limit_fault,
    output logic                seg_unloaded,
    output logic [RIGHTS_W-1:0] ref_rights
);

    seg_desc_t cur;
    logic      cur_loaded;
    logic      over;

    always_comb begin
        cur        = desc_arr[ref_seg];
        cur_loaded = loaded[ref_seg];
        over       = ref_offset > cur.limit;
        phys_addr  = form_addr(cur.base, ref_offset);
        ref_rights = cur.rights;
        seg_unloaded = ref_valid && !cur_loaded;
        limit_fault  = ref_valid && cur_loaded && over;
        addr_valid   = ref_valid && cur_loaded && !over;
    end

    // R7: a limit fault never comes with a valid address
    a_r7_fault_blocks_valid: assert property (@(posedge clk) disable iff (rst)
        limit_fault |-> !addr_valid);

    // R8: unloaded reference reports neither address nor limit fault
    a_r8_unloaded_exclusive: assert property (@(posedge clk) disable iff (rst)
        seg_unloaded |-> (!addr_valid && !limit_fault));

    // R6: outputs only qualify when a reference is made
    a_r6_needs_request: assert property (@(posedge clk) disable iff (rst)
        (addr_valid || limit_fault || seg_unloaded) |-> ref_valid);

endmodule

// File: rtl/segdesc_cache.sv
module segdesc_cache
    import segcache_pkg::*;
#(
    parameter int N = SEG_COUNT,
    localparam int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_valid,
    input  logic [IW-1:0]       ld_seg,
    input  logic [SEL_W-1:0]    ld_selector,
    input  logic [BASE_W-1:0]   ld_base,
    input  logic [LIMIT_W-1:0]  ld_limit,
    input  logic [RIGHTS_W-1:0] ld_rights,
    output logic                type_fault,
    input  logic [IW-1:0]       rd_seg,
    output logic [SEL_W-1:0]    rd_selector,
    input  logic                ref_valid,
    input  logic [IW-1:0]       ref_seg,
    input  logic [OFFSET_W-1:0] ref_offset,
    output logic [BASE_W-1:0]   phys_addr,
    output logic                addr_valid,
    output logic                limit_fault,
    output logic                seg_unloaded,
    output logic [RIGHTS_W-1:0] ref_rights
);

    logic [N-1:0]            we;
    logic [N-1:0][SEL_W-1:0] sel_arr;
    seg_desc_t [N-1:0]       desc_arr;
    logic [N-1:0]            loaded;
    seg_desc_t               ld_desc;

    assign ld_desc = '{base: ld_base, limit: ld_limit, rights: ld_rights};

    segcache_load_ctrl #(.N(N)) u_load (
        .clk        (clk),
        .rst        (rst),
        .ld_valid   (ld_valid),
        .ld_seg     (ld_seg),
        .ld_rights  (ld_rights),
        .we         (we),
        .type_fault (type_fault)
    );

    segcache_entry_bank #(.N(N)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .we          (we),
        .ld_selector (ld_selector),
        .ld_desc     (ld_desc),
        .sel_arr     (sel_arr),
        .desc_arr    (desc_arr),
        .loaded      (loaded)
    );

    segcache_addr_gen #(.N(N)) u_agen (
        .clk          (clk),
        .rst          (rst),
        .ref_valid    (ref_valid),
        .ref_seg      (ref_seg),
        .ref_offset   (ref_offset),
        .desc_arr     (desc_arr),
        .loaded       (loaded),
        .phys_addr    (phys_addr),
        .addr_valid   (addr_valid),
        .limit_fault  (limit_fault),
        .seg_unloaded (seg_unloaded),
        .ref_rights   (ref_rights)
    );

    assign rd_selector = sel_arr[rd_seg];

    // R4: the cycle a refusal is reported, no selector changed at the preceding edge
    a_r4_refusal_keeps_state: assert property (@(posedge clk) disable iff (rst)
        type_fault |-> $stable(sel_arr));

endmodule

// File: tb/segdesc_cache_test.sv
module segdesc_cache_test;
    import segcache_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_valid;
    logic [1:0]  ld_seg;
    logic [15:0] ld_selector;
    logic [23:0] ld_base;
    logic [15:0] ld_limit;
    logic [7:0]  ld_rights;
    logic        type_fault;
    logic [1:0]  rd_seg;
    logic [15:0] rd_selector;
    logic        ref_valid;
    logic [1:0]  ref_seg;
    logic [15:0] ref_offset;
    logic [23:0] phys_addr;
    logic        addr_valid;
    logic        limit_fault;
    logic        seg_unloaded;
    logic [7:0]  ref_rights;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    segdesc_cache uut (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_selector(ld_selector),
        .ld_base(ld_base), .ld_limit(ld_limit), .ld_rights(ld_rights),
        .type_fault(type_fault),
        .rd_seg(rd_seg), .rd_selector(rd_selector),
        .ref_valid(ref_valid), .ref_seg(ref_seg), .ref_offset(ref_offset),
        .phys_addr(phys_addr), .addr_valid(addr_valid), .limit_fault(limit_fault),
        .seg_unloaded(seg_unloaded), .ref_rights(ref_rights)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one load request held for one edge; afterwards we sit at a negedge
    task automatic do_load(input logic [1:0] s, input logic [15:0] sel,
                           input logic [23:0] b, input logic [15:0] l, input logic [7:0] r);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = s; ld_selector = sel;
        ld_base = b; ld_limit = l; ld_rights = r;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic check_ref(input string req, input logic [1:0] s, input logic [15:0] off,
                             input logic [23:0] exp_addr, input logic exp_v,
                             input logic exp_lf, input logic exp_un);
        ref_valid = 1'b1; ref_seg = s; ref_offset = off;
        #1;
        if (exp_v) chk({req, " addr"}, 32'(phys_addr), 32'(exp_addr));
        chk({req, " addr_valid"}, 32'(addr_valid), 32'(exp_v));
        chk({req, " limit_fault"}, 32'(limit_fault), 32'(exp_lf));
        chk({req, " seg_unloaded"}, 32'(seg_unloaded), 32'(exp_un));
        ref_valid = 1'b0;
    endtask

    task automatic check_sel(input string req, input logic [1:0] s, input logic [15:0] exp);
        rd_seg = s; #1;
        chk(req, 32'(rd_selector), 32'(exp));
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            check_sel("R1 selector after reset", 2'(i), 16'h0);
            check_ref("R1 R8 unloaded after reset", 2'(i), 16'h0, 24'h0, 1'b0, 1'b0, 1'b1);
        end
        chk("R1 type_fault after reset", 32'(type_fault), 32'h0);
    endtask

    task automatic t_load_and_ref;
        do_load(SEG_CODE, 16'h0008, 24'h010000, 16'h0FFF, 8'h9A);
        chk("R2 no type_fault on good load", 32'(type_fault), 32'h0);
        check_sel("R2 R5 code selector", SEG_CODE, 16'h0008);
        check_ref("R6 code offset", SEG_CODE, 16'h0123, 24'h010123, 1'b1, 1'b0, 1'b0);
        chk("R2 rights cached", 32'(ref_rights), 32'h9A);
        check_ref("R6 offset equal limit", SEG_CODE, 16'h0FFF, 24'h010FFF, 1'b1, 1'b0, 1'b0);
        check_ref("R7 offset past limit", SEG_CODE, 16'h1000, 24'h0, 1'b0, 1'b1, 1'b0);
        check_ref("R8 data still unloaded", SEG_DATA, 16'h0000, 24'h0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_wrap_and_isolation;
        do_load(SEG_STACK, 16'h0010, 24'hFFFF00, 16'hFFFF, 8'h92);
        check_ref("R6 base wrap", SEG_STACK, 16'h0200, 24'h000100, 1'b1, 1'b0, 1'b0);
        check_ref("R6 top offset", SEG_STACK, 16'hFFFF, 24'h00FEFF, 1'b1, 1'b0, 1'b0);
        check_ref("R3 code untouched", SEG_CODE, 16'h0123, 24'h010123, 1'b1, 1'b0, 1'b0);
        check_sel("R3 code selector kept", SEG_CODE, 16'h0008);
        do_load(SEG_EXTRA, 16'h0023, 24'h400000, 16'h0000, 8'h93);
        check_sel("R2 extra selector", SEG_EXTRA, 16'h0023);
        check_ref("R6 zero limit offset 0", SEG_EXTRA, 16'h0000, 24'h400000, 1'b1, 1'b0, 1'b0);
        check_ref("R7 zero limit offset 1", SEG_EXTRA, 16'h0001, 24'h0, 1'b0, 1'b1, 1'b0);
        check_sel("R3 stack selector kept", SEG_STACK, 16'h0010);
    endtask

    task automatic t_reject;
        do_load(SEG_DATA, 16'h0018, 24'h123456, 16'h00FF, 8'h82);
        chk("R4 type_fault pulse", 32'(type_fault), 32'h1);
        check_sel("R4 data selector kept", SEG_DATA, 16'h0000);
        check_ref("R4 data still unloaded", SEG_DATA, 16'h0000, 24'h0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R4 type_fault one cycle", 32'(type_fault), 32'h0);
        do_load(SEG_CODE, 16'h0777, 24'h555555, 16'h0001, 8'h05);
        chk("R4 type_fault on code", 32'(type_fault), 32'h1);
        check_sel("R4 code selector kept", SEG_CODE, 16'h0008);
        check_ref("R4 code entry kept", SEG_CODE, 16'h0FFF, 24'h010FFF, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R4 type_fault drops", 32'(type_fault), 32'h0);
    endtask

    task automatic t_repeat_refs;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_ref("R9 repeated ref", SEG_STACK, 16'h0080, 24'hFFFF80, 1'b1, 1'b0, 1'b0);
        end
        check_sel("R9 selector after refs", SEG_STACK, 16'h0010);
    endtask

    task automatic t_reload;
        do_load(SEG_CODE, 16'h0030, 24'h200000, 16'h00FF, 8'h9B);
        check_sel("R10 new selector", SEG_CODE, 16'h0030);
        check_ref("R10 new base", SEG_CODE, 16'h0010, 24'h200010, 1'b1, 1'b0, 1'b0);
        check_ref("R10 new limit", SEG_CODE, 16'h0100, 24'h0, 1'b0, 1'b1, 1'b0);
        chk("R10 new rights", 32'(ref_rights), 32'h9B);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = SEG_CODE; ld_selector = 16'h0038;
        ld_base = 24'h300000; ld_limit = 16'hFFFF; ld_rights = 8'h9A;
        ref_valid = 1'b1; ref_seg = SEG_CODE; ref_offset = 16'h0005;
        #1;
        chk("R11 old base before edge", 32'(phys_addr), 32'h200005);
        @(negedge clk);
        ld_valid = 1'b0;
        #1;
        chk("R11 new base after edge", 32'(phys_addr), 32'h300005);
        chk("R11 valid after edge", 32'(addr_valid), 32'h1);
        ref_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; ld_valid = 1'b0; ld_seg = '0; ld_selector = '0;
        ld_base = '0; ld_limit = '0; ld_rights = '0; rd_seg = '0;
        ref_valid = 1'b0; ref_seg = '0; ref_offset = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_and_ref();
        t_wrap_and_isolation();
        t_reject();
        t_repeat_refs();
        t_reload();
        t_same_cycle();
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule